// File: doc/BRIEF.md
# Multi-Port Register File with Last-Writer Steering

This block is a register file with several write ports that store on the clock edge and several read ports that return data without a clock. It is meant for the integer and floating-point register files of a processor on FPGA fabric. It avoids one large flip-flop array with wide write-decode and read multiplexers. Instead, every write port keeps its own full copy of the word space. That copy has a small storage bank with one combinational read path for each read port. A bank of this shape maps onto LUT-based distributed memory.

Because each bank only sees the writes of its own port, the banks disagree on a word once different ports have written it. A tracking table holds one small entry per word that names the write port which last stored that word. Each read port looks up its address in this table and takes the data from the bank it names. Word count, data width, write-port count and read-port count are independent parameters. A further parameter makes word 0 a constant zero.

Top module: `lvt_regfile`

## Requirements
- R1: A word written through any enabled write port at a rising clock edge is returned by every read port addressing it from that edge on, until the word is written again.
- R2: Read data is combinational: when `rd_addr` of a port changes with no clock edge, `rd_data` of that port shows the stored content of the new address in the same cycle.
- R3: All read ports operate independently; each can address any word, and different ports can address different words in the same cycle.
- R4: When different write ports have written the same word at different times, a read returns the value from the write that happened most recently, whichever port made it.
- R5: When two or more enabled write ports target the same word at the same edge, the port with the highest index wins, and later reads return its data.
- R6: A read of a word that is being written in the current cycle returns the old content; the new data appears only after the clock edge.
- R7: With `ZERO_WORD0` set (the default), word 0 always reads as zero and writes to address 0 are discarded.
- R8: After the synchronous active-high reset, every word reads as zero.
- R9: A write port with its enable bit low changes no word, whatever its address and data inputs carry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; writes take effect on its rising edge |
| rst | input | 1 | Synchronous active-high reset; clears all words and the tracking table |
| wr_en | input | NUM_WR | Write enable, one bit per write port |
| wr_addr | input | NUM_WR x ADDR_W | Word address for each write port |
| wr_data | input | NUM_WR x DATA_W | Write data for each write port |
| rd_addr | input | NUM_RD x ADDR_W | Word address for each read port |
| rd_data | output | NUM_RD x DATA_W | Combinational read data for each read port |

## Verification
Address collisions are the main target. A random phase confines its addresses to a few words, so that both write ports often hit the same word in one cycle. A design that let the wrong port win, or that updated the table and the bank out of step, would return the losing port's data. A read of the same word in the cycle of its write is checked to return the old value; a design that forwarded write data would fail this check. The bench also writes to word 0 from both ports, holds enables low while the address and data inputs change, and moves read addresses between clock edges. A writable zero word, a write that ignores its enable, or a read path that was registered would each show up as wrong data at the read ports.

// File: rtl/lvt_rf_pkg.sv
package lvt_rf_pkg;

  // Number of bits needed to index n items (at least one bit).
  function automatic int sel_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/lvt_bank.sv
// One storage bank owned by a single write port. It holds every word and
// gives each read port its own combinational read path (distributed-memory shape).
module lvt_bank #(
  parameter int NUM_WORDS  = 32,
  parameter int DATA_W     = 32,
  parameter int NUM_RD     = 3,
  parameter int ADDR_W     = 5,
  parameter bit ZERO_WORD0 = 1'b1
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          we,
  input  logic [ADDR_W-1:0]             waddr,
  input  logic [DATA_W-1:0]             wdata,
  input  logic [NUM_RD-1:0][ADDR_W-1:0] raddr,
  output logic [NUM_RD-1:0][DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] mem [NUM_WORDS];
  logic              wr_ok;

  assign wr_ok = we && !(ZERO_WORD0 && (waddr == '0));

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_WORDS; i++) mem[i] <= '0;
    end else if (wr_ok) begin
      mem[waddr] <= wdata;
    end
  end

  for (genvar r = 0; r < NUM_RD; r++) begin : g_rd
    assign rdata[r] = mem[raddr[r]];
  end

  // A write that was accepted must have landed at its address.
  assert_bank_write_R1: assert property (@(posedge clk) disable iff (rst)
    wr_ok |=> (mem[$past(waddr)] == $past(wdata)));

  // The constant word never holds anything but zero.
  assert_bank_zero_R7: assert property (@(posedge clk) disable iff (rst)
    ZERO_WORD0 |-> (mem[0] == '0));

endmodule

// File: rtl/lvt_table.sv
// Per-word record of the write port that most recently stored that word.
module lvt_table #(
  parameter int NUM_WORDS  = 32,
  parameter int NUM_WR     = 2,
  parameter int NUM_RD     = 3,
  parameter int ADDR_W     = 5,
  parameter int SEL_W      = 1,
  parameter bit ZERO_WORD0 = 1'b1
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [NUM_WR-1:0]             we,
  input  logic [NUM_WR-1:0][ADDR_W-1:0] waddr,
  input  logic [NUM_RD-1:0][ADDR_W-1:0] raddr,
  output logic [NUM_RD-1:0][SEL_W-1:0]  rsel
);

  logic [SEL_W-1:0]  owner [NUM_WORDS];
  logic [NUM_WR-1:0] accept;

  for (genvar p = 0; p < NUM_WR; p++) begin : g_acc
    assign accept[p] = we[p] && !(ZERO_WORD0 && (waddr[p] == '0));
  end

  // Ports are visited in ascending order, so the highest colliding port
  // is the last assignment and wins.
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_WORDS; i++) owner[i] <= '0;
    end else begin
      for (int p = 0; p < NUM_WR; p++) begin
        if (accept[p]) owner[waddr[p]] <= SEL_W'(p);
      end
    end
  end

  for (genvar r = 0; r < NUM_RD; r++) begin : g_rsel
    assign rsel[r] = owner[raddr[r]];
  end

  // The top port never loses a collision.
  assert_top_port_wins_R5: assert property (@(posedge clk) disable iff (rst)
    accept[NUM_WR-1] |=> (owner[$past(waddr[NUM_WR-1])] == SEL_W'(NUM_WR-1)));

  // Right after reset every word points to port 0.
  assert_owner_reset_R8: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (rsel[0] == '0));

endmodule

// File: rtl/lvt_read_mux.sv
// Chooses, for one read port, the bank named by the tracking table.
module lvt_read_mux #(
  parameter int NUM_WR     = 2,
  parameter int DATA_W     = 32,
  parameter int ADDR_W     = 5,
  parameter int SEL_W      = 1,
  parameter bit ZERO_WORD0 = 1'b1
) (
  input  logic [SEL_W-1:0]              sel,
  input  logic [ADDR_W-1:0]             addr,
  input  logic [NUM_WR-1:0][DATA_W-1:0] bank_data,
  output logic [DATA_W-1:0]             dout
);

  logic [DATA_W-1:0] picked;

  always_comb begin
    picked = '0;
    for (int p = 0; p < NUM_WR; p++) begin
      if (sel == SEL_W'(p)) picked = bank_data[p];
    end
  end

  if (ZERO_WORD0) begin : g_zero
    assign dout = (addr == '0) ? '0 : picked;
  end else begin : g_plain
    assign dout = picked;
  end

endmodule

// File: rtl/lvt_regfile.sv
module lvt_regfile
  import lvt_rf_pkg::*;
#(
  parameter int NUM_WORDS  = 32,
  parameter int DATA_W     = 32,
  parameter int NUM_WR     = 2,
  parameter int NUM_RD     = 3,
  parameter bit ZERO_WORD0 = 1'b1,
  localparam int ADDR_W    = sel_width(NUM_WORDS),
  localparam int SEL_W     = sel_width(NUM_WR)
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [NUM_WR-1:0]             wr_en,
  input  logic [NUM_WR-1:0][ADDR_W-1:0] wr_addr,
  input  logic [NUM_WR-1:0][DATA_W-1:0] wr_data,
  input  logic [NUM_RD-1:0][ADDR_W-1:0] rd_addr,
  output logic [NUM_RD-1:0][DATA_W-1:0] rd_data
);

  logic [NUM_WR-1:0][NUM_RD-1:0][DATA_W-1:0] bank_out;
  logic [NUM_RD-1:0][NUM_WR-1:0][DATA_W-1:0] per_port;
  logic [NUM_RD-1:0][SEL_W-1:0]              sel;

  for (genvar w = 0; w < NUM_WR; w++) begin : g_bank
    lvt_bank #(
      .NUM_WORDS (NUM_WORDS),
      .DATA_W    (DATA_W),
      .NUM_RD    (NUM_RD),
      .ADDR_W    (ADDR_W),
      .ZERO_WORD0(ZERO_WORD0)
    ) u_bank (
      .clk  (clk),
      .rst  (rst),
      .we   (wr_en[w]),
      .waddr(wr_addr[w]),
      .wdata(wr_data[w]),
      .raddr(rd_addr),
      .rdata(bank_out[w])
    );
    for (genvar r = 0; r < NUM_RD; r++) begin : g_xpose
      assign per_port[r][w] = bank_out[w][r];
    end
  end

  lvt_table #(
    .NUM_WORDS (NUM_WORDS),
    .NUM_WR    (NUM_WR),
    .NUM_RD    (NUM_RD),
    .ADDR_W    (ADDR_W),
    .SEL_W     (SEL_W),
    .ZERO_WORD0(ZERO_WORD0)
  ) u_table (
    .clk  (clk),
    .rst  (rst),
    .we   (wr_en),
    .waddr(wr_addr),
    .raddr(rd_addr),
    .rsel (sel)
  );

  for (genvar r = 0; r < NUM_RD; r++) begin : g_mux
    lvt_read_mux #(
      .NUM_WR    (NUM_WR),
      .DATA_W    (DATA_W),
      .ADDR_W    (ADDR_W),
      .SEL_W     (SEL_W),
      .ZERO_WORD0(ZERO_WORD0)
    ) u_mux (
      .sel      (sel[r]),
      .addr     (rd_addr[r]),
      .bank_data(per_port[r]),
      .dout     (rd_data[r])
    );
  end

endmodule

// File: tb/tb_lvt_regfile.sv
module tb_lvt_regfile;

  localparam int NW = 32;
  localparam int DW = 32;
  localparam int NWR = 2;
  localparam int NRD = 3;
  localparam int AW = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NWR-1:0]         wr_en = '0;
  logic [NWR-1:0][AW-1:0] wr_addr = '0;
  logic [NWR-1:0][DW-1:0] wr_data = '0;
  logic [NRD-1:0][AW-1:0] rd_addr = '0;
  logic [NRD-1:0][DW-1:0] rd_data;

  int checks = 0;
  int errors = 0;
  logic [DW-1:0] model [NW];

  always #4 clk = ~clk;  // 125 MHz

  lvt_regfile dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  function automatic logic [DW-1:0] expect_rd(input logic [AW-1:0] a);
    return (a == '0) ? '0 : model[a];
  endfunction

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic check_ports(input string req);
    #1;
    for (int r = 0; r < NRD; r++) chk(req, rd_data[r], expect_rd(rd_addr[r]));
  endtask

  // Check reads in the current cycle, pass one edge, apply the model update
  // in ascending port order (higher port overwrites), return at the negedge.
  task automatic step(input string req);
    check_ports(req);
    @(posedge clk);
    #1;
    for (int p = 0; p < NWR; p++)
      if (wr_en[p] && wr_addr[p] != '0) model[wr_addr[p]] = wr_data[p];
    @(negedge clk);
  endtask

  initial begin
    #(8 * 60000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < NW; i++) model[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R8: every word zero after reset, swept on port 0
    for (int a = 0; a < NW; a++) begin
      rd_addr[0] = AW'(a);
      #1 chk("R8", rd_data[0], '0);
    end

    // R6 then R1: write word 5 from port 0, read in same cycle then next
    wr_en = 2'b01; wr_addr[0] = 5'd5; wr_data[0] = 32'hA5A5_0001;
    rd_addr = {5'd5, 5'd5, 5'd5};
    #1 chk("R6", rd_data[1], 32'h0);
    step("R6");
    wr_en = '0;
    #1 chk("R1", rd_data[2], 32'hA5A5_0001);

    // R4: port 1 rewrites word 5, port 0 writes word 7
    wr_en = 2'b10; wr_addr[1] = 5'd5; wr_data[1] = 32'hB00B_0002;
    step("R4");
    wr_en = 2'b01; wr_addr[0] = 5'd7; wr_data[0] = 32'hC0DE_0003;
    step("R4");
    wr_en = '0;
    #1 chk("R4", rd_data[2], 32'hB00B_0002);

    // R5: both ports write word 9 in one cycle, port 1 must win
    wr_en = 2'b11;
    wr_addr[0] = 5'd9; wr_data[0] = 32'h1111_1111;
    wr_addr[1] = 5'd9; wr_data[1] = 32'h2222_2222;
    rd_addr = {5'd9, 5'd9, 5'd9};
    step("R5");
    wr_en = '0;
    #1 chk("R5", rd_data[0], 32'h2222_2222);
    // R4: port 0 later writes word 9 alone and must take over
    wr_en = 2'b01; wr_data[0] = 32'h3333_3333;
    step("R4");
    wr_en = '0;
    #1 chk("R4", rd_data[1], 32'h3333_3333);

    // R7: both ports write word 0, it must still read zero
    wr_en = 2'b11; wr_addr = '0; wr_data = {32'hFFFF_FFFF, 32'hDEAD_BEEF};
    rd_addr = '0;
    step("R7");
    wr_en = '0;
    #1 chk("R7", rd_data[0], 32'h0);
    chk("R7", rd_data[2], 32'h0);

    // R9: enables low while address and data toggle toward word 9
    wr_en = '0; wr_addr = {5'd9, 5'd9}; wr_data = {32'h4444_4444, 32'h5555_5555};
    rd_addr = {5'd9, 5'd9, 5'd9};
    step("R9");
    #1 chk("R9", rd_data[2], 32'h3333_3333);

    // R3: three ports, three different words in one cycle
    rd_addr = {5'd7, 5'd9, 5'd5};
    #1 chk("R3", rd_data[0], 32'hB00B_0002);
    chk("R3", rd_data[1], 32'h3333_3333);
    chk("R3", rd_data[2], 32'hC0DE_0003);

    // R2: move read addresses with no clock edge in between
    for (int a = 0; a < NW; a++) begin
      rd_addr[1] = AW'(a);
      #1 chk("R2", rd_data[1], expect_rd(AW'(a)));
    end

    // R4/R5/R6 random phase: narrow address range forces collisions
    for (int n = 0; n < 3000; n++) begin
      wr_en = NWR'($urandom);
      for (int p = 0; p < NWR; p++) begin
        wr_addr[p] = ($urandom_range(0, 3) == 0) ? AW'($urandom) : AW'($urandom_range(0, 5));
        wr_data[p] = $urandom;
      end
      for (int r = 0; r < NRD; r++)
        rd_addr[r] = ($urandom_range(0, 1) == 0) ? wr_addr[r % NWR] : AW'($urandom_range(0, 7));
      step("R4");
    end
    wr_en = '0;
    check_ports("R4");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule